// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This controller turns single transfer requests from inside the chip into cycles on an external bus. On that bus the low sixteen address bits and the data share one set of lines, and an address strobe separates the two phases. The upper address bits have lines of their own. The top bits of the request address pick one of eight memory spaces. Each space has its own chip select, its own data width (8 or 16 bits) and its own count of programmed wait states (0 to 7). A slow device can stretch a cycle further through an external wait input. An optional idle cycle can follow each transfer. An external master can take over the bus through a hold request and acknowledge handshake.

A requester presents a request and holds it until a one-cycle completion pulse comes back. For a read, the returned data is valid on that pulse. Requests aimed at an on-chip peripheral put the peripheral's address on the address lines and nothing else. Requests aimed at internal memory release the shared lines. Neither kind asserts any external strobe or chip select, and both complete in a single cycle.

Top module: `mux_bus_ctrl`

## Requirements
- R1: An external transfer begins with an address cycle. In that cycle `astb` is 1, `ad_out` carries address bits 15..0, `addr_hi` carries bits 23..16 and `ad_oe` is 1. The cycle starts on the clock edge after the controller, while idle, samples `req_valid`=1 with `req_target`=0.
- R2: The space index is address bits 23..21. Only `cs_n[index]` is low, and it is low during the address cycle and the data cycles. All chip selects are high at every other time.
- R3: Spaces with `cfg_bus16[i]`=1 are 16 bits wide. A 16-bit access (`req_wide`=1) to such a space takes one beat with both write strobes. A byte access uses the lane chosen by address bit 0 (0 = low lane, `wr_lo_n`; 1 = high lane, `wr_hi_n`), and the byte read from that lane is returned in `resp_rdata[7:0]` with the upper bits zero.
- R4: A 16-bit access to an 8-bit space takes two beats. The first beat uses the even address and the second the odd address. Both beats use the low lane and `wr_lo_n`. The first beat carries bits 7..0 and the second bits 15..8, and a read assembles the word in the same order.
- R5: The read or write strobe stays low for W+1 cycles, where W = `cfg_waits[3i+2:3i]` of the addressed space.
- R6: `ext_wait` is sampled only once the programmed waits are over. Each cycle it is then found high adds one data cycle. While the programmed waits are still running it has no effect.
- R7: With `idle_en`=1 there is one more cycle between a completion and the next address cycle. Back to back, that gap is 3 cycles instead of 2.
- R8: `hold_req` is granted only while the controller is idle, never between the two beats of a split access. While `hold_ack`=1, `ctrl_oe`, `addr_oe` and `ad_oe` are 0 and no new cycle starts.
- R9: `hold_ack` falls on the first clock edge that samples `hold_req`=0. On that same edge the controller drives the bus again (`ctrl_oe`=`addr_oe`=1).
- R10: A request with `req_target`=1 (peripheral) drives its address on `ad_out`/`addr_hi` with `ad_oe`=1. All strobes stay inactive and all chip selects high, and `resp_done` pulses one cycle after acceptance.
- R11: A request with `req_target`=2 (internal memory) releases the shared lines (`ad_oe`=0), keeps all strobes inactive and pulses `resp_done` one cycle after acceptance.
- R12: After reset the following hold: all `cs_n` are 1; `rd_n`, `wr_lo_n` and `wr_hi_n` are 1; `astb`, `ad_oe`, `hold_ack` and `resp_done` are 0; `ctrl_oe` and `addr_oe` are 1.
- R13: During the data cycles of a write, `ad_oe`=1 and `ad_out` carries the write data. A byte beat repeats its byte on both lanes. During a read, `ad_oe`=0, and `rd_n` and the write strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present; held until `resp_done` |
| req_target | input | 2 | 0 external, 1 peripheral, 2 internal memory |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1 sixteen-bit, 0 byte access |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 16 | Read data, valid with `resp_done` |
| cfg_bus16 | input | 8 | Per-space width, 1 = 16-bit |
| cfg_waits | input | 24 | Per-space programmed waits, 3 bits each |
| idle_en | input | 1 | Insert an idle cycle after each transfer |
| ext_wait | input | 1 | External wait, active high |
| hold_req | input | 1 | External master asks for the bus |
| hold_ack | output | 1 | Bus surrendered |
| ad_out | output | 16 | Shared address/data lines, out |
| ad_in | input | 16 | Shared address/data lines, in |
| ad_oe | output | 1 | Drive enable of the shared lines |
| addr_hi | output | 8 | Upper address lines |
| addr_oe | output | 1 | Drive enable of the upper address lines |
| ctrl_oe | output | 1 | Drive enable of strobes and chip selects |
| astb | output | 1 | Address strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_lo_n | output | 1 | Low-byte write strobe, active low |
| wr_hi_n | output | 1 | High-byte write strobe, active low |
| cs_n | output | 8 | Chip selects, active low |

## Verification
The assertions take several things for granted. The requester holds its request fields steady from `req_valid` until `resp_done` and drops `req_valid` right after the pulse. The space configuration does not change during a transfer, 16-bit accesses use even addresses, and `ext_wait` never stays high without end. The wait-length check also relies on the programmed count being latched when a request is accepted. The stimulus meets these assumptions in several ways. Every transfer goes through one task that drives the request at a falling edge and clears it on the completion pulse. The configuration is set once, before the sweep. External wait is only ever raised for a bounded number of data cycles, and the hold request is raised either while idle or between the two beats of a split read.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_DATA, S_END, S_GAP, S_HOLD, S_LOCAL
  } mbc_state_t;

  localparam logic [1:0] TGT_EXT  = 2'd0;
  localparam logic [1:0] TGT_PERI = 2'd1;
endpackage

// File: rtl/mbc_space_cfg.sv
module mbc_space_cfg #(
  parameter int CS_N   = 8,
  parameter int WAIT_W = 3
) (
  input  logic [$clog2(CS_N)-1:0] idx,
  input  logic [CS_N-1:0]         cfg_bus16,
  input  logic [CS_N*WAIT_W-1:0]  cfg_waits,
  output logic                    bus16,
  output logic [WAIT_W-1:0]       waits
);
  logic [WAIT_W-1:0] wtab [CS_N];

  for (genvar i = 0; i < CS_N; i++) begin : g_tab
    assign wtab[i] = cfg_waits[i*WAIT_W +: WAIT_W];
  end

  assign bus16 = cfg_bus16[idx];
  assign waits = wtab[idx];
endmodule

// File: rtl/mbc_lane.sv
module mbc_lane #(
  parameter int AD_W = 16
) (
  input  logic            bus16,
  input  logic            wide,
  input  logic            beat,
  input  logic            a0,
  input  logic [AD_W-1:0] wdata,
  input  logic [AD_W-1:0] ad_in,
  input  logic [AD_W-1:0] rd_prev,
  output logic            split,
  output logic            lo_en,
  output logic            hi_en,
  output logic [AD_W-1:0] drive,
  output logic [AD_W-1:0] rd_next
);
  localparam int B = AD_W / 2;

  logic         full;
  logic [B-1:0] wbyte;

  assign full  = wide & bus16;
  assign split = wide & ~bus16;
  assign lo_en = bus16 ? (wide | ~a0) : 1'b1;
  assign hi_en = bus16 & (wide | a0);
  assign wbyte = (split && beat) ? wdata[AD_W-1:B] : wdata[B-1:0];
  assign drive = full ? wdata : {wbyte, wbyte};

  always_comb begin
    if (full)
      rd_next = ad_in;
    else if (split)
      rd_next = beat ? {ad_in[B-1:0], rd_prev[B-1:0]} : {{B{1'b0}}, ad_in[B-1:0]};
    else if (bus16 && a0)
      rd_next = {{B{1'b0}}, ad_in[AD_W-1:B]};
    else
      rd_next = {{B{1'b0}}, ad_in[B-1:0]};
  end
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int AD_W   = 16,
  parameter int CS_N   = 8,
  parameter int WAIT_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [1:0]             req_target,
  input  logic                   req_write,
  input  logic                   req_wide,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [AD_W-1:0]        req_wdata,
  output logic                   resp_done,
  output logic [AD_W-1:0]        resp_rdata,
  input  logic [CS_N-1:0]        cfg_bus16,
  input  logic [CS_N*WAIT_W-1:0] cfg_waits,
  input  logic                   idle_en,
  input  logic                   ext_wait,
  input  logic                   hold_req,
  output logic                   hold_ack,
  output logic [AD_W-1:0]        ad_out,
  input  logic [AD_W-1:0]        ad_in,
  output logic                   ad_oe,
  output logic [ADDR_W-AD_W-1:0] addr_hi,
  output logic                   addr_oe,
  output logic                   ctrl_oe,
  output logic                   astb,
  output logic                   rd_n,
  output logic                   wr_lo_n,
  output logic                   wr_hi_n,
  output logic [CS_N-1:0]        cs_n
);
  localparam int SEL_W = $clog2(CS_N);

  mbc_state_t st, st_d;

  logic [ADDR_W-1:0] cur_addr, cur_addr_d;
  logic [AD_W-1:0]   cur_wdata, cur_wdata_d;
  logic              cur_wr, cur_wr_d, cur_wide, cur_wide_d, cur_beat, cur_beat_d;
  logic              cur_bus16, cur_bus16_d;
  logic [SEL_W-1:0]  cur_sel, cur_sel_d;
  logic [WAIT_W-1:0] cur_waits, cur_waits_d, wcnt, wcnt_d;

  logic [AD_W-1:0]        ad_out_d, rdata_d;
  logic [ADDR_W-AD_W-1:0] addr_hi_d;
  logic [CS_N-1:0]        cs_n_d;
  logic ad_oe_d, addr_oe_d, ctrl_oe_d, astb_d, rd_n_d, wrl_d, wrh_d, ack_d, done_d;

  logic [SEL_W-1:0]  sp_sel;
  logic              sp_bus16;
  logic [WAIT_W-1:0] sp_waits;
  logic              idle_st, act_bus16, act_wide, act_a0;
  logic              ln_split, ln_lo, ln_hi;
  logic [AD_W-1:0]   ln_drive, ln_rd;

  assign sp_sel    = req_addr[ADDR_W-1 -: SEL_W];
  assign idle_st   = (st == S_IDLE);
  assign act_bus16 = idle_st ? sp_bus16 : cur_bus16;
  assign act_wide  = idle_st ? req_wide : cur_wide;
  assign act_a0    = idle_st ? req_addr[0] : cur_addr[0];

  mbc_space_cfg #(.CS_N(CS_N), .WAIT_W(WAIT_W)) u_cfg (
    .idx(sp_sel), .cfg_bus16(cfg_bus16), .cfg_waits(cfg_waits),
    .bus16(sp_bus16), .waits(sp_waits)
  );

  mbc_lane #(.AD_W(AD_W)) u_lane (
    .bus16(act_bus16), .wide(act_wide), .beat(cur_beat), .a0(act_a0),
    .wdata(cur_wdata), .ad_in(ad_in), .rd_prev(resp_rdata),
    .split(ln_split), .lo_en(ln_lo), .hi_en(ln_hi),
    .drive(ln_drive), .rd_next(ln_rd)
  );

  always_comb begin
    logic [ADDR_W-1:0] baddr;
    baddr       = cur_addr;
    st_d        = st;
    cur_addr_d  = cur_addr;
    cur_wdata_d = cur_wdata;
    cur_wr_d    = cur_wr;
    cur_wide_d  = cur_wide;
    cur_beat_d  = cur_beat;
    cur_bus16_d = cur_bus16;
    cur_sel_d   = cur_sel;
    cur_waits_d = cur_waits;
    wcnt_d      = wcnt;
    ad_out_d    = ad_out;
    addr_hi_d   = addr_hi;
    rdata_d     = resp_rdata;
    ad_oe_d     = 1'b0;
    addr_oe_d   = 1'b1;
    ctrl_oe_d   = 1'b1;
    astb_d      = 1'b0;
    rd_n_d      = 1'b1;
    wrl_d       = 1'b1;
    wrh_d       = 1'b1;
    cs_n_d      = '1;
    ack_d       = 1'b0;
    done_d      = 1'b0;
    case (st)
      S_IDLE: begin
        if (hold_req) begin
          st_d = S_HOLD; ack_d = 1'b1; ctrl_oe_d = 1'b0; addr_oe_d = 1'b0;
        end else if (req_valid) begin
          cur_addr_d  = req_addr;
          cur_wdata_d = req_wdata;
          cur_wr_d    = req_write;
          cur_wide_d  = req_wide;
          cur_beat_d  = 1'b0;
          cur_bus16_d = sp_bus16;
          cur_sel_d   = sp_sel;
          cur_waits_d = sp_waits;
          if (req_target == TGT_EXT) begin
            baddr = req_addr;
            if (ln_split) baddr[0] = 1'b0;
            st_d      = S_ADDR;
            ad_out_d  = baddr[AD_W-1:0];
            addr_hi_d = baddr[ADDR_W-1:AD_W];
            ad_oe_d   = 1'b1;
            astb_d    = 1'b1;
            cs_n_d[sp_sel] = 1'b0;
          end else begin
            st_d    = S_LOCAL;
            done_d  = 1'b1;
            rdata_d = '0;
            if (req_target == TGT_PERI) begin
              ad_out_d  = req_addr[AD_W-1:0];
              addr_hi_d = req_addr[ADDR_W-1:AD_W];
              ad_oe_d   = 1'b1;
            end
          end
        end
      end
      S_ADDR, S_DATA: begin
        cs_n_d[cur_sel] = 1'b0;
        rd_n_d  = cur_wr;
        wrl_d   = !(cur_wr && ln_lo);
        wrh_d   = !(cur_wr && ln_hi);
        ad_oe_d = cur_wr;
        if (cur_wr) ad_out_d = ln_drive;
        if (st == S_ADDR) begin
          st_d   = S_DATA;
          wcnt_d = cur_waits;
        end else if (wcnt != '0) begin
          wcnt_d = wcnt - 1'b1;
        end else if (!ext_wait) begin
          st_d    = S_END;
          cs_n_d  = '1;
          rd_n_d  = 1'b1;
          wrl_d   = 1'b1;
          wrh_d   = 1'b1;
          ad_oe_d = 1'b0;
          if (!cur_wr) rdata_d = ln_rd;
          done_d  = !ln_split || cur_beat;
        end
      end
      S_END: begin
        if (ln_split && !cur_beat) begin
          baddr      = {cur_addr[ADDR_W-1:1], 1'b1};
          cur_beat_d = 1'b1;
          st_d       = S_ADDR;
          ad_out_d   = baddr[AD_W-1:0];
          addr_hi_d  = baddr[ADDR_W-1:AD_W];
          ad_oe_d    = 1'b1;
          astb_d     = 1'b1;
          cs_n_d[cur_sel] = 1'b0;
        end else begin
          st_d = idle_en ? S_GAP : S_IDLE;
        end
      end
      S_GAP:   st_d = S_IDLE;
      S_HOLD: begin
        if (hold_req) begin
          ack_d = 1'b1; ctrl_oe_d = 1'b0; addr_oe_d = 1'b0;
        end else begin
          st_d = S_IDLE;
        end
      end
      S_LOCAL: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      cur_addr <= '0; cur_wdata <= '0; cur_wr <= 1'b0; cur_wide <= 1'b0;
      cur_beat <= 1'b0; cur_bus16 <= 1'b0; cur_sel <= '0; cur_waits <= '0; wcnt <= '0;
      ad_out <= '0; addr_hi <= '0; resp_rdata <= '0;
      ad_oe <= 1'b0; addr_oe <= 1'b1; ctrl_oe <= 1'b1; astb <= 1'b0;
      rd_n <= 1'b1; wr_lo_n <= 1'b1; wr_hi_n <= 1'b1; cs_n <= '1;
      hold_ack <= 1'b0; resp_done <= 1'b0;
    end else begin
      st <= st_d;
      cur_addr <= cur_addr_d; cur_wdata <= cur_wdata_d; cur_wr <= cur_wr_d;
      cur_wide <= cur_wide_d; cur_beat <= cur_beat_d; cur_bus16 <= cur_bus16_d;
      cur_sel <= cur_sel_d; cur_waits <= cur_waits_d; wcnt <= wcnt_d;
      ad_out <= ad_out_d; addr_hi <= addr_hi_d; resp_rdata <= rdata_d;
      ad_oe <= ad_oe_d; addr_oe <= addr_oe_d; ctrl_oe <= ctrl_oe_d; astb <= astb_d;
      rd_n <= rd_n_d; wr_lo_n <= wrl_d; wr_hi_n <= wrh_d; cs_n <= cs_n_d;
      hold_ack <= ack_d; resp_done <= done_d;
    end
  end

  // Strobe-length watcher for the wait check
  logic       strb;
  logic [7:0] scnt;
  assign strb = !rd_n || !wr_lo_n || !wr_hi_n;
  always_ff @(posedge clk) begin
    if (rst) scnt <= '0;
    else if (!strb) scnt <= '0;
    else if (scnt != 8'hFF) scnt <= scnt + 8'd1;
  end

  assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
  assert_addr_phase_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    astb |-> (rd_n && wr_lo_n && wr_hi_n && ad_oe && (cs_n != '1)));
  assert_split_odd_R4: assert property (@(posedge clk) disable iff (rst)
    (astb && cur_beat) |-> ad_out[0]);
  assert_wait_min_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(strb) |-> (scnt > 8'(cur_waits)));
  assert_strobe_excl_R13: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && (!wr_lo_n || !wr_hi_n)));
  assert_hold_float_R8: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> (!ctrl_oe && !addr_oe && !ad_oe && !astb));
  assert_hold_boundary_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> ($past(st) == S_IDLE));
  assert_hold_release_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_ack) |-> (!$past(hold_req) && ctrl_oe && addr_oe));
endmodule

// File: tb/mux_bus_ctrl_tb.sv
module mux_bus_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        req_valid = 0, req_write = 0, req_wide = 0;
  logic [1:0]  req_target = 0;
  logic [23:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic        resp_done;
  logic [15:0] resp_rdata;
  logic [7:0]  cfg_bus16 = 8'b1010_1010;
  logic [23:0] cfg_waits;
  logic        idle_en = 0, ext_wait = 0, hold_req = 0, hold_ack;
  logic [15:0] ad_out, ad_in;
  logic [7:0]  addr_hi, cs_n;
  logic        ad_oe, addr_oe, ctrl_oe, astb, rd_n, wr_lo_n, wr_hi_n;

  mux_bus_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_target(req_target),
    .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
    .req_wdata(req_wdata), .resp_done(resp_done), .resp_rdata(resp_rdata),
    .cfg_bus16(cfg_bus16), .cfg_waits(cfg_waits), .idle_en(idle_en),
    .ext_wait(ext_wait), .hold_req(hold_req), .hold_ack(hold_ack),
    .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .addr_hi(addr_hi),
    .addr_oe(addr_oe), .ctrl_oe(ctrl_oe), .astb(astb), .rd_n(rd_n),
    .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n), .cs_n(cs_n)
  );

  for (genvar i = 0; i < 8; i++) begin : g_w
    assign cfg_waits[i*3 +: 3] = 3'(i);
  end

  // External device model: data derived from the latched address
  logic [23:0] lat = 0;
  function automatic logic [15:0] devdata(input logic [23:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] ^ 8'hC3};
  endfunction
  always @(negedge clk) if (astb) lat <= {addr_hi, ad_out};
  assign ad_in = devdata(lat);

  int total = 0, bad = 0, cycles = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Per-transfer record
  int          nb, dlen[2];
  logic [23:0] baddr[2];
  logic [7:0]  bcs[2];
  logic [15:0] bdat[2], rres;
  bit          brd[2], bwl[2], bwh[2], boe[2], ackmid;

  task automatic xfer(input bit wr, input bit wide, input logic [23:0] a,
                      input logic [15:0] wd, input bit hold_mid, input int ew_drop);
    int n = 0;
    @(negedge clk);
    req_target = 2'd0; req_write = wr; req_wide = wide; req_addr = a; req_wdata = wd;
    req_valid = 1; nb = 0; ackmid = 0;
    if (ew_drop > 0) ext_wait = 1;
    for (int k = 0; k < 2; k++) begin
      dlen[k] = 0; brd[k] = 0; bwl[k] = 0; bwh[k] = 0; boe[k] = 0; bdat[k] = 0;
    end
    do begin
      @(negedge clk); n++;
      if (astb && nb < 2) begin
        baddr[nb] = {addr_hi, ad_out}; bcs[nb] = cs_n; nb++;
        if (hold_mid && nb == 1) hold_req = 1;
      end
      if (nb > 0 && (!rd_n || !wr_lo_n || !wr_hi_n)) begin
        dlen[nb-1]++;
        brd[nb-1] = !rd_n; bwl[nb-1] = !wr_lo_n; bwh[nb-1] = !wr_hi_n;
        boe[nb-1] = ad_oe; bdat[nb-1] = ad_out;
        if (ew_drop > 0 && dlen[nb-1] == ew_drop) ext_wait = 0;
      end
      if (hold_ack) ackmid = 1;
    end while (!resp_done && n < 400);
    rres = resp_rdata;
    req_valid = 0; ext_wait = 0;
  endtask

  task automatic sweep_op(input int s, input int op);
    bit b16 = s[0];
    bit wr = (op >= 1 && op <= 3);
    bit wide = (op < 2);
    logic [23:0] a = {s[2:0], 21'h012346};
    logic [23:0] ad = (op >= 3) ? (a | 24'd1) : a;
    logic [15:0] wd = 16'hA55A ^ 16'(s * 16'h0111 + op);
    bit sp = wide && !b16;
    int enb = sp ? 2 : 1;
    logic [15:0] er;
    xfer(wr, wide, ad, wd, 0, 0);
    chk(nb == enb, "R4 beat count", nb, enb);
    for (int b = 0; b < enb && b < nb; b++) begin
      logic [23:0] ea = sp ? {ad[23:1], 1'(b)} : ad;
      logic [7:0] bb = (sp && b == 1) ? wd[15:8] : wd[7:0];
      bit ewl = wr && (b16 ? (wide || !ad[0]) : 1'b1);
      bit ewh = wr && b16 && (wide || ad[0]);
      chk(baddr[b] == ea, "R1 address phase", baddr[b], ea);
      chk(bcs[b] == ~(8'd1 << s), "R2 chip select", bcs[b], ~(8'd1 << s));
      chk(dlen[b] == s + 1, "R5 data length", dlen[b], s + 1);
      chk({brd[b], bwl[b], bwh[b]} == {!wr, ewl, ewh}, "R3 strobes",
          {brd[b], bwl[b], bwh[b]}, {!wr, ewl, ewh});
      chk(boe[b] == wr, "R13 drive enable", boe[b], wr);
      if (wr) begin
        logic [15:0] ed = (wide && b16) ? wd : {bb, bb};
        chk(bdat[b] == ed, "R13 write data", bdat[b], ed);
      end
    end
    if (!wr) begin
      if (wide && b16) er = devdata(ad);
      else if (sp) er = {devdata({ad[23:1], 1'b1})[7:0], devdata({ad[23:1], 1'b0})[7:0]};
      else if (b16 && ad[0]) er = {8'h00, devdata(ad)[15:8]};
      else er = {8'h00, devdata(ad)[7:0]};
      chk(rres == er, sp ? "R4 read assembly" : "R3 read lane", rres, er);
    end
  endtask

  task automatic gap_test(input bit ie, output int gap);
    int n = 0, td = -1;
    gap = -1;
    idle_en = ie;
    @(negedge clk);
    req_target = 0; req_write = 0; req_wide = 0; req_addr = 24'h000010; req_valid = 1;
    while (gap < 0 && n < 100) begin
      @(negedge clk); n++;
      if (resp_done && td < 0) td = n;
      else if (astb && td >= 0) gap = n - td;
    end
    req_valid = 0;
    n = 0;
    while (!resp_done && n < 100) begin @(negedge clk); n++; end
    @(negedge clk);
    idle_en = 0;
    @(negedge clk);
  endtask

  initial begin
    int g;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk(cs_n == 8'hFF && rd_n && wr_lo_n && wr_hi_n, "R12 strobes idle",
        {cs_n, rd_n, wr_lo_n, wr_hi_n}, {8'hFF, 3'b111});
    chk(!astb && !ad_oe && !hold_ack && !resp_done && ctrl_oe && addr_oe, "R12 enables",
        {astb, ad_oe, hold_ack, resp_done, ctrl_oe, addr_oe}, 6'b000011);

    // Sweep all spaces and access shapes
    for (int s = 0; s < 8; s++)
      for (int op = 0; op < 5; op++)
        sweep_op(s, op);

    // R6 external wait on space 2 (W=2)
    xfer(0, 1, 24'h400020, 0, 0, 6);
    chk(dlen[0] == 6, "R6 wait stretch", dlen[0], 6);
    xfer(0, 1, 24'h400020, 0, 0, 2);
    chk(dlen[0] == 3, "R6 wait ignored during programmed waits", dlen[0], 3);

    // R7 idle insertion
    gap_test(0, g);
    chk(g == 2, "R7 gap without idle", g, 2);
    gap_test(1, g);
    chk(g == 3, "R7 gap with idle", g, 3);

    // R8/R9 hold while idle
    @(negedge clk); hold_req = 1;
    @(negedge clk);
    chk(hold_ack && !ctrl_oe && !addr_oe && !ad_oe, "R8 bus floated",
        {hold_ack, ctrl_oe, addr_oe, ad_oe}, 4'b1000);
    req_target = 0; req_write = 0; req_wide = 0; req_addr = 24'h000040; req_valid = 1;
    begin
      bit seen = 0;
      repeat (3) begin @(negedge clk); if (astb) seen = 1; end
      chk(!seen, "R8 no cycle during hold", seen, 0);
    end
    req_valid = 0;
    @(negedge clk); hold_req = 0;
    @(negedge clk);
    chk(!hold_ack && ctrl_oe && addr_oe, "R9 release", {hold_ack, ctrl_oe, addr_oe}, 3'b011);

    // R8 hold raised between split beats
    xfer(0, 1, 24'h000080, 0, 1, 0);
    chk(nb == 2 && !ackmid, "R8 no grant mid split", {nb[7:0], 7'd0, ackmid}, 16'h0200);
    begin
      bit got = 0;
      repeat (4) begin @(negedge clk); if (hold_ack) got = 1; end
      chk(got, "R8 grant after split", got, 1);
    end
    hold_req = 0;
    repeat (2) @(negedge clk);

    // R10 peripheral access
    req_target = 2'd1; req_addr = 24'hABCDEF; req_valid = 1;
    @(negedge clk);
    chk(resp_done && ad_oe && ad_out == 16'hCDEF && addr_hi == 8'hAB, "R10 address only",
        {resp_done, ad_oe, addr_hi, ad_out}, {2'b11, 24'hABCDEF});
    chk(cs_n == 8'hFF && !astb && rd_n && wr_lo_n && wr_hi_n, "R10 strobes inactive",
        {cs_n, astb, rd_n, wr_lo_n, wr_hi_n}, {8'hFF, 4'b0111});
    req_valid = 0;
    @(negedge clk);

    // R11 internal memory access
    req_target = 2'd2; req_addr = 24'h123456; req_valid = 1;
    @(negedge clk);
    chk(resp_done && !ad_oe && cs_n == 8'hFF && !astb && rd_n && wr_lo_n && wr_hi_n,
        "R11 internal", {resp_done, ad_oe, cs_n, astb, rd_n, wr_lo_n, wr_hi_n},
        {2'b10, 8'hFF, 4'b0111});
    req_valid = 0;
    repeat (2) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule